// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block decides how a small 8-bit processor core enters an interrupt. It watches three request lines: a non-maskable one, a fast one and a normal one. It holds the two interrupt mask flags of the condition-code register and a wait-for-interrupt flag. Each time the core offers it an evaluation slot (`step`), it picks the highest eligible source and advances that source's own phase tracker by one stage. The stages are: stack the registers, fetch the vector, then resume at the handler.

For each accepted step the block reports the action, the source and the cycle cost of that stage. It keeps the two bus status pins in the state that matches the current stage. It also folds every reported cost into a wide running total. The total can be read either directly or as the amount added since the last read strobe. Halt and bus-request inputs suspend the sequencing and override the status pins.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `bus_avail`=0, `bus_state`=0, `imask`=1, `fmask`=1, `wait_flag`=0, `evt_valid`=0, `total_cycles`=0, and every source's tracker is idle, so the first accepted step for any source reports a stacking action.
- R2: On an accepted step a pending non-maskable request always wins. The fast request is considered only when the non-maskable one is absent. The normal request is considered only when neither higher source wins.
- R3: `cc_wr` loads `imask` from `cc_imask_in` and `fmask` from `cc_fmask_in` at the next edge. An idle fast source is passed over while `fmask`=1, and an idle normal source is passed over while `imask`=1. The non-maskable source ignores both flags.
- R4: A winning source moves through stack (`evt_act`=1), vector (`evt_act`=2) and resume (`evt_act`=3), one stage per accepted step, and is then idle again. A step with no winner reports `evt_act`=0 and `evt_src`=0. `evt_src` is 1 for non-maskable, 2 for fast and 3 for normal.
- R5: The stack stage drives `bus_state` low. The vector stage drives `bus_state` high. The resume stage drives both `bus_avail` and `bus_state` low.
- R6: `evt_cycles` is 15 for a non-maskable or normal stack stage, 6 for a fast stack stage, 2 for a vector or resume stage, and 0 when there is no winner.
- R7: `sync_exec` sets `wait_flag` and drives `bus_avail` high and `bus_state` low. Any accepted step that sees no non-maskable request but sees a fast or normal request clears `wait_flag`, even if the request is masked. A non-maskable sequence clears it only at its resume stage.
- R8: While `halt` is high, both status pins are high. In the cycle after `halt` falls, both are low.
- R9: In the cycle after `bus_req` falls, `bus_avail` equals `wait_flag` and `bus_state` is low. While `bus_req` is high (and `halt` is low), both pins are high.
- R10: `total_cycles` grows by `evt_cycles` in the same cycle the event is reported. `delta_cycles` is `total_cycles` minus the value captured at the last `cnt_rd` strobe, so it reads 0 just after a strobe.
- R11: A step is accepted only when `halt` and `bus_req` are low and were low in the previous cycle. The step is reported with `evt_valid`=1 one cycle later. `sync_exec` is ignored under the same conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request level |
| firq_req | input | 1 | Fast request level |
| irq_req | input | 1 | Normal request level |
| cc_wr | input | 1 | Load the mask flags |
| cc_imask_in | input | 1 | New normal mask value |
| cc_fmask_in | input | 1 | New fast mask value |
| step | input | 1 | Evaluation slot from the core |
| sync_exec | input | 1 | Wait-for-interrupt instruction executed |
| halt | input | 1 | Halt level |
| bus_req | input | 1 | Bus request level |
| cnt_rd | input | 1 | Capture the total for the delta view |
| imask | output | 1 | Normal mask flag |
| fmask | output | 1 | Fast mask flag |
| wait_flag | output | 1 | Waiting for interrupt |
| bus_avail | output | 1 | Bus-available status pin |
| bus_state | output | 1 | Bus-status pin |
| evt_valid | output | 1 | A step was accepted last cycle |
| evt_act | output | 2 | Action: 0 none, 1 stack, 2 vector, 3 resume |
| evt_src | output | 2 | Source: 0 none, 1 non-maskable, 2 fast, 3 normal |
| evt_cycles | output | 5 | Cycle cost of the reported stage |
| total_cycles | output | 64 | Running cycle total |
| delta_cycles | output | 64 | Total added since the last `cnt_rd` |

## Verification
All register-driven results of a stimulus (event fields, status pins, mask and wait flags, and the total) are due exactly one clock after the edge that samples it. The delta view is combinational on registered state, so it is also due one clock later. The bench therefore drives inputs at the falling edge and compares against a behavioural model, advanced at the rising edge, at every following falling edge. The directed checks read the outputs at that same falling edge, right after the single rising edge that consumed the stimulus. Halt and bus-request release are checked in the cycle after the level falls, which is the same cycle in which a step is refused.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int CNT_W     = 64,
  parameter int NMI_COST  = 19,
  parameter int FIRQ_COST = 10,
  parameter int IRQ_COST  = 19,
  parameter int VEC_COST  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_req,
  input  logic             firq_req,
  input  logic             irq_req,
  input  logic             cc_wr,
  input  logic             cc_imask_in,
  input  logic             cc_fmask_in,
  input  logic             step,
  input  logic             sync_exec,
  input  logic             halt,
  input  logic             bus_req,
  input  logic             cnt_rd,
  output logic             imask,
  output logic             fmask,
  output logic             wait_flag,
  output logic             bus_avail,
  output logic             bus_state,
  output logic             evt_valid,
  output logic [1:0]       evt_act,
  output logic [1:0]       evt_src,
  output logic [4:0]       evt_cycles,
  output logic [CNT_W-1:0] total_cycles,
  output logic [CNT_W-1:0] delta_cycles
);
  localparam logic [1:0] PH_RUN = 2'd0, PH_PUSH = 2'd1, PH_VEC = 2'd2;
  localparam logic [4:0] C_NMI = 5'(NMI_COST - 4);
  localparam logic [4:0] C_FIRQ = 5'(FIRQ_COST - 4);
  localparam logic [4:0] C_IRQ = 5'(IRQ_COST - 4);
  localparam logic [4:0] C_VEC = 5'(VEC_COST);

  logic [1:0] ph [3];
  logic [1:0] eff [3];
  logic [2:0] req, masked, elig;
  logic       halt_q, breq_q, take;
  logic [1:0] win, nact;
  logic [4:0] ncyc;
  logic [CNT_W-1:0] snap;

  assign req    = {irq_req, firq_req, nmi_req};
  assign masked = {imask, fmask, 1'b0};
  assign take   = step && !halt && !halt_q && !bus_req && !breq_q;

  for (genvar s = 0; s < 3; s++) begin : g_src
    assign eff[s]  = (ph[s] == 2'd3) ? PH_RUN : ph[s];
    assign elig[s] = req[s] && !(eff[s] == PH_RUN && masked[s]);
  end

  assign win = elig[0] ? 2'd1 : elig[1] ? 2'd2 : elig[2] ? 2'd3 : 2'd0;

  always_comb begin
    nact = 2'd0;
    ncyc = 5'd0;
    if (win != 2'd0) begin
      case (eff[win - 2'd1])
        PH_RUN:  begin
          nact = 2'd1;
          ncyc = (win == 2'd1) ? C_NMI : (win == 2'd2) ? C_FIRQ : C_IRQ;
        end
        PH_PUSH: begin nact = 2'd2; ncyc = C_VEC; end
        default: begin nact = 2'd3; ncyc = C_VEC; end
      endcase
    end
  end

  assign delta_cycles = total_cycles - snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 3; s++) ph[s] <= PH_RUN;
      {imask, fmask} <= 2'b11;
      {wait_flag, bus_avail, bus_state, halt_q, breq_q} <= '0;
      {evt_valid, evt_act, evt_src, evt_cycles} <= '0;
      total_cycles <= '0;
      snap <= '0;
    end else begin
      halt_q <= halt;
      breq_q <= bus_req;
      if (cc_wr) {imask, fmask} <= {cc_imask_in, cc_fmask_in};
      if (cnt_rd) snap <= total_cycles;
      evt_valid  <= take;
      evt_act    <= take ? nact : 2'd0;
      evt_src    <= take ? win : 2'd0;
      evt_cycles <= take ? ncyc : 5'd0;
      if (take) total_cycles <= total_cycles + CNT_W'(ncyc);
      if (halt) begin
        bus_avail <= 1'b1;
        bus_state <= 1'b1;
      end else if (halt_q) begin
        bus_avail <= 1'b0;
        bus_state <= 1'b0;
      end else if (bus_req) begin
        bus_avail <= 1'b1;
        bus_state <= 1'b1;
      end else if (breq_q) begin
        bus_avail <= wait_flag;
        bus_state <= 1'b0;
      end else begin
        if (sync_exec) begin
          wait_flag <= 1'b1;
          bus_avail <= 1'b1;
          bus_state <= 1'b0;
        end
        if (take) begin
          if (!req[0] && (req[1] || req[2])) wait_flag <= 1'b0;
          if (win != 2'd0) begin
            case (nact)
              2'd1: begin
                bus_state <= 1'b0;
                ph[win - 2'd1] <= PH_PUSH;
              end
              2'd2: begin
                bus_state <= 1'b1;
                ph[win - 2'd1] <= PH_VEC;
              end
              default: begin
                bus_avail <= 1'b0;
                bus_state <= 1'b0;
                ph[win - 2'd1] <= PH_RUN;
                if (win == 2'd1) wait_flag <= 1'b0;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

module irq_entry_seq_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_req,
  input logic             halt,
  input logic             fmask,
  input logic             bus_avail,
  input logic             bus_state,
  input logic             evt_valid,
  input logic [1:0]       evt_act,
  input logic [1:0]       evt_src,
  input logic [4:0]       evt_cycles,
  input logic [CNT_W-1:0] total_cycles
);
  assert_halt_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (bus_avail && bus_state));
  assert_push_bs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_act == 2'd1) |-> !bus_state);
  assert_vec_bs_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_act == 2'd2) |-> bus_state);
  assert_resume_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_act == 2'd3) |-> (!bus_avail && !bus_state));
  assert_total_add_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> total_cycles == $past(total_cycles) + CNT_W'(evt_cycles));
  assert_total_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> $stable(total_cycles));
  assert_nmi_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_src != 2'd1) |-> !$past(nmi_req));
  assert_fmask_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_src == 2'd2 && evt_act == 2'd1) |-> !$past(fmask));
  assert_vec_cost_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_act == 2'd2) |-> evt_cycles == 5'd2);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .halt(halt), .fmask(fmask),
  .bus_avail(bus_avail), .bus_state(bus_state), .evt_valid(evt_valid),
  .evt_act(evt_act), .evt_src(evt_src), .evt_cycles(evt_cycles),
  .total_cycles(total_cycles)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic nmi_req = 0, firq_req = 0, irq_req = 0;
  logic cc_wr = 0, cc_imask_in = 0, cc_fmask_in = 0;
  logic step = 0, sync_exec = 0, halt = 0, bus_req = 0, cnt_rd = 0;
  logic imask, fmask, wait_flag, bus_avail, bus_state, evt_valid;
  logic [1:0] evt_act, evt_src;
  logic [4:0] evt_cycles;
  logic [63:0] total_cycles, delta_cycles;

  irq_entry_seq i_irq_entry_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, errors = 0;
  bit modeling = 0;

  // behavioural reference
  int m_phase [3];
  bit m_im, m_fm, m_wait, m_ba, m_bs, m_hq, m_bq, m_val;
  int m_act, m_src, m_cyc;
  logic [63:0] m_tot, m_snap;

  task automatic model_edge();
    bit ok, r[3], msk[3];
    int w;
    bit in_im, in_fm;
    if (!rst_n) begin
      m_phase = '{0, 0, 0};
      m_im = 1; m_fm = 1; m_wait = 0; m_ba = 0; m_bs = 0; m_hq = 0; m_bq = 0;
      m_val = 0; m_act = 0; m_src = 0; m_cyc = 0; m_tot = 0; m_snap = 0;
      return;
    end
    ok = step && !halt && !m_hq && !bus_req && !m_bq;
    r = '{nmi_req, firq_req, irq_req};
    msk = '{0, m_fm, m_im};
    in_im = m_im; in_fm = m_fm;
    if (cnt_rd) m_snap = m_tot;
    m_val = ok; m_act = 0; m_src = 0; m_cyc = 0;
    if (halt) begin m_ba = 1; m_bs = 1; end
    else if (m_hq) begin m_ba = 0; m_bs = 0; end
    else if (bus_req) begin m_ba = 1; m_bs = 1; end
    else if (m_bq) begin m_ba = m_wait; m_bs = 0; end
    else begin
      if (sync_exec) begin m_wait = 1; m_ba = 1; m_bs = 0; end
      if (ok) begin
        w = -1;
        for (int s = 0; s < 3; s++) begin
          if (!r[s]) continue;
          if (s > 0) m_wait = 0;
          if (m_phase[s] == 0 && msk[s]) continue;
          w = s; break;
        end
        if (w >= 0) begin
          m_src = w + 1;
          if (m_phase[w] == 0) begin
            m_act = 1; m_cyc = (w == 1) ? 6 : 15; m_bs = 0; m_phase[w] = 1;
          end else if (m_phase[w] == 1) begin
            m_act = 2; m_cyc = 2; m_bs = 1; m_phase[w] = 2;
          end else begin
            m_act = 3; m_cyc = 2; m_ba = 0; m_bs = 0; m_phase[w] = 0;
            if (w == 0) m_wait = 0;
          end
        end
      end
    end
    if (ok) m_tot = m_tot + 64'(m_cyc);
    if (cc_wr) begin m_im = cc_imask_in; m_fm = cc_fmask_in; end
    m_hq = halt; m_bq = bus_req;
    if (in_im && in_fm && 0) m_im = m_im;
  endtask

  always @(posedge clk) model_edge();

  task automatic chk(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (modeling && rst_n) begin
    chk("R4 act", evt_act, m_act);
    chk("R2 src", evt_src, m_src);
    chk("R11 valid", evt_valid, m_val);
    chk("R6 cycles", evt_cycles, m_cyc);
    chk("R5 ba", bus_avail, m_ba);
    chk("R5 bs", bus_state, m_bs);
    chk("R7 wait", wait_flag, m_wait);
    chk("R3 imask", imask, m_im);
    chk("R3 fmask", fmask, m_fm);
    chk("R10 total", total_cycles, m_tot);
    chk("R10 delta", delta_cycles, m_tot - m_snap);
  end

  task automatic tick();
    @(negedge clk);
    step = 0; sync_exec = 0; cc_wr = 0; cnt_rd = 0;
  endtask

  task automatic do_step();
    step = 1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    modeling = 1;
    chk("R1 ba", bus_avail, 0); chk("R1 bs", bus_state, 0);
    chk("R1 imask", imask, 1); chk("R1 fmask", fmask, 1);
    chk("R1 total", total_cycles, 0); chk("R1 valid", evt_valid, 0);
    cc_wr = 1; cc_imask_in = 0; cc_fmask_in = 0; tick();
    chk("R3 load", {imask, fmask}, 0);
    nmi_req = 1; irq_req = 1;
    do_step();
    chk("R2 nmi src", evt_src, 1); chk("R4 push", evt_act, 1);
    chk("R6 nmi push", evt_cycles, 15); chk("R5 bs low", bus_state, 0);
    step = 0;
    do_step(); chk("R4 vec", evt_act, 2); chk("R5 bs high", bus_state, 1);
    step = 0;
    do_step(); chk("R4 resume", evt_act, 3); chk("R5 low", {bus_avail, bus_state}, 0);
    chk("R10 total", total_cycles, 19);
    nmi_req = 0; step = 0;
    for (int k = 0; k < 3; k++) begin do_step(); step = 0; end
    chk("R2 normal next", evt_src, 3); chk("R10 total", total_cycles, 38);
    cc_wr = 1; cc_fmask_in = 1; tick();
    firq_req = 1;
    do_step(); chk("R3 fast masked", evt_src, 3); step = 0;
    do_step(); step = 0; do_step(); step = 0;
    irq_req = 0;
    cc_wr = 1; cc_fmask_in = 0; tick();
    do_step(); chk("R6 fast push", evt_cycles, 6); chk("R2 fast src", evt_src, 2); step = 0;
    do_step(); step = 0; do_step(); step = 0;
    firq_req = 0;
    chk("R10 total", total_cycles, 67);
    chk("R10 delta", delta_cycles, 67);
    cnt_rd = 1; tick();
    chk("R10 delta zero", delta_cycles, 0);
    sync_exec = 1; tick();
    chk("R7 wait", wait_flag, 1); chk("R7 ba", bus_avail, 1); chk("R7 bs", bus_state, 0);
    cc_wr = 1; cc_imask_in = 1; cc_fmask_in = 1; tick();
    firq_req = 1;
    do_step(); chk("R7 cleared masked", wait_flag, 0); chk("R4 none", evt_act, 0);
    chk("R6 none", evt_cycles, 0);
    step = 0; firq_req = 0;
    sync_exec = 1; tick();
    nmi_req = 1;
    do_step(); chk("R7 nmi keeps", wait_flag, 1); step = 0;
    do_step(); step = 0;
    do_step(); chk("R7 nmi clears", wait_flag, 0); step = 0;
    nmi_req = 0;
    chk("R10 total", total_cycles, 86);
    halt = 1; tick();
    chk("R8 halt pins", {bus_avail, bus_state}, 3);
    irq_req = 1;
    do_step(); chk("R11 halt refuse", evt_valid, 0); step = 0;
    halt = 0;
    do_step(); chk("R8 release", {bus_avail, bus_state}, 0);
    chk("R11 release refuse", evt_valid, 0); step = 0;
    irq_req = 0;
    sync_exec = 1; tick();
    bus_req = 1; tick();
    chk("R9 busy pins", {bus_avail, bus_state}, 3);
    bus_req = 0; tick();
    chk("R9 end ba", bus_avail, 1); chk("R9 end bs", bus_state, 0);
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 30 == 0) halt = ~halt;
      if ($urandom % 25 == 0) bus_req = ~bus_req;
      nmi_req = ($urandom % 4 == 0);
      firq_req = ($urandom % 3 == 0);
      irq_req = ($urandom % 2 == 0);
      step = ($urandom % 2 == 0);
      sync_exec = ($urandom % 12 == 0);
      cc_wr = ($urandom % 8 == 0);
      cc_imask_in = $urandom % 2;
      cc_fmask_in = $urandom % 2;
      cnt_rd = ($urandom % 9 == 0);
      @(negedge clk);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule